// File: doc/BRIEF.md
# Channel Receive Sequencer

This block drives the receive half of a character multiplexer's link to an I/O channel. A start command moves it out of idle. It then fetches a channel command and, once the fetch is accepted, forwards every normal character that arrives from the line receivers into memory. Each character is stored as two consecutive byte writes: the character first, then the number of the line it came from. After both writes it raises a receive interrupt request. When the channel reports that the byte count is exhausted, the sequencer asks the channel to end the command. A chained command then sends it back to fetch another command. Any other good response sends it to idle.

Every line has a receive buffer and a break flag. These are updated whatever the sequencer state is. A break marks the line and is never written to memory. A normal character clears the mark and is held in the buffer. A disconnect clears both. A halt command returns the sequencer to idle from any state. It cancels a write in flight and clears the interrupt requests. A status word reports whether the sequencer is busy.

Top module: `chan_rx_seq`

## Requirements
- R1: While reset is held and on leaving it, state_o is 0 (idle), status_o is 4'b0001, and cmd_req_o, end_req_o, mem_req_o, rx_irq_o and uend_o are all 0, while char_ready_o is 1 and every line's buffer and break flag read back as 0.
- R2: The state codes are idle 0, init 1, receive 2 and end 3. A start_i seen in idle without halt_i gives state 1 on the next cycle. A start_i seen in any other state has no effect.
- R3: In init, cmd_req_o is 1. A cmd_ack_i with cmd_err_i low gives state 2 next cycle. A cmd_ack_i with cmd_err_i high gives state 0 and a one-cycle uend_o pulse next cycle.
- R4: In receive, an accepted normal character produces a memory request carrying the character. After that request is acknowledged, a second request carries the line number, zero-extended to DATA_W. Each request and its data stay unchanged until mem_ack_i.
- R5: An error-free acknowledge of the line-number write sets rx_irq_o on the next cycle. If mem_zbc_i is high with that acknowledge, the state becomes 3 instead of staying 2.
- R6: In end, end_req_o is 1. An end_ack_i with end_err_i gives state 0 and a uend_o pulse. An end_ack_i with end_chain_i gives state 1. Any other end_ack_i gives state 0.
- R7: halt_i gives state 0, rx_irq_o low and no memory request on the next cycle, with a one-cycle xmt_irq_clr_o pulse. Halt overrides a start or an acknowledge in the same cycle.
- R8: An accepted character with char_brk_i set sets that line's break flag and writes nothing to memory. The line's buffer is left unchanged. An accepted normal character clears the flag and loads the buffer.
- R9: disc_i clears the break flag and the buffer of disc_line_i. It takes priority over a character arriving for the same line in the same cycle.
- R10: Outside the receive state, accepted characters update only the line buffers and flags, and mem_req_o stays 0.
- R11: status_o bits are [0] automatic, [1] controller busy, [2] device busy and [3] condition code 2. The word is 4'b0001 in idle and 4'b1111 in every other state.
- R12: A memory acknowledge with mem_err_i high ends the transfer: state 0 and a uend_o pulse on the next cycle, with no interrupt request.
- R13: char_ready_o is 0 while a two-byte write is in progress. A character offered then is not taken and does not change any line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start command |
| halt_i | input | 1 | Halt command |
| cmd_req_o | output | 1 | Channel command fetch request |
| cmd_ack_i | input | 1 | Command fetch response |
| cmd_err_i | input | 1 | Fetch response is an error |
| end_req_o | output | 1 | Channel end request |
| end_ack_i | input | 1 | Channel end response |
| end_chain_i | input | 1 | End response asks for command chaining |
| end_err_i | input | 1 | End response is an error |
| uend_o | output | 1 | Unusual-end report pulse |
| status_o | output | 4 | Status word |
| state_o | output | 2 | Sequencer state code |
| char_valid_i | input | 1 | Received character present |
| char_ready_o | output | 1 | Character can be taken |
| char_data_i | input | DATA_W | Received character |
| char_line_i | input | LINE_W | Line that received it |
| char_brk_i | input | 1 | Received item is a break |
| disc_i | input | 1 | Line disconnect |
| disc_line_i | input | LINE_W | Disconnected line |
| mem_req_o | output | 1 | Memory byte write request |
| mem_data_o | output | DATA_W | Byte to write |
| mem_ack_i | input | 1 | Write acknowledge |
| mem_err_i | input | 1 | Write acknowledge carries an error |
| mem_zbc_i | input | 1 | Byte count reached zero with this acknowledge |
| rx_irq_o | output | 1 | Receive interrupt request |
| xmt_irq_clr_o | output | 1 | Clear pulse for the transmit interrupt request |
| qry_line_i | input | LINE_W | Line to read back |
| qry_data_o | output | DATA_W | Buffer of the selected line |
| qry_brk_o | output | 1 | Break flag of the selected line |

## Verification
Several corner cases are targeted. The first is a halt in the middle of a two-byte write. A design that let the pending line-number byte through would leave mem_req_o high after the halt, or raise an interrupt. The bench holds each acknowledge back for a few cycles. A sequencer that moved on without waiting would change mem_data_o while the request was still pending. Two chained transfers in a row show whether end returns to init or wrongly drops to idle. Breaks, disconnects and characters are sent while idle and while a write is busy. A design that wrote breaks to memory, or took characters while it was not ready, would show a buffer or break flag that differs from the reference model.

// File: rtl/chan_rx_pkg.sv
package chan_rx_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_INIT = 2'd1,
      SQ_RECV = 2'd2,
      SQ_END  = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      WR_OFF  = 2'd0,
      WR_CHAR = 2'd1,
      WR_LINE = 2'd2
   } wr_phase_t;

   localparam int STAT_W     = 4;
   localparam int STAT_AUTO  = 0;
   localparam int STAT_CBUSY = 1;
   localparam int STAT_DBUSY = 2;
   localparam int STAT_CC2   = 3;
endpackage

// File: rtl/chan_rx_lines.sv
module chan_rx_lines #(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [LINE_W-1:0] upd_line,
   input  logic              upd_brk,
   input  logic [DATA_W-1:0] upd_data,
   input  logic              clr_en,
   input  logic [LINE_W-1:0] clr_line,
   input  logic [LINE_W-1:0] rd_line,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_brk
);
   logic [DATA_W-1:0] hold_q [LINES];
   logic [LINES-1:0]  brk_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic hit_upd, hit_clr;
      assign hit_upd = upd_en && (int'(upd_line) == g);
      assign hit_clr = clr_en && (int'(clr_line) == g);

      always_ff @(posedge clk) begin
         if (!rst_n || hit_clr) begin
            hold_q[g] <= '0;
            brk_q[g]  <= 1'b0;
         end else if (hit_upd) begin
            if (upd_brk) begin
               brk_q[g] <= 1'b1;
            end else begin
               brk_q[g]  <= 1'b0;
               hold_q[g] <= upd_data;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      rd_brk  = 1'b0;
      if (int'(rd_line) < LINES) begin
         rd_data = hold_q[rd_line];
         rd_brk  = brk_q[rd_line];
      end
   end
endmodule

// File: rtl/chan_rx_wr.sv
module chan_rx_wr
   import chan_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              abort,
   input  logic [DATA_W-1:0] char_in,
   input  logic [LINE_W-1:0] line_in,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              mem_zbc,
   output logic              mem_req,
   output logic [DATA_W-1:0] mem_data,
   output logic              idle,
   output logic              done,
   output logic              zbc,
   output logic              err
);
   wr_phase_t         ph_q;
   logic [DATA_W-1:0] char_q;
   logic [LINE_W-1:0] line_q;

   assign mem_req  = (ph_q != WR_OFF);
   assign idle     = (ph_q == WR_OFF);
   assign mem_data = (ph_q == WR_LINE) ? DATA_W'(line_q) : char_q;
   assign err      = mem_req && mem_ack && mem_err;
   assign done     = (ph_q == WR_LINE) && mem_ack && !mem_err;
   assign zbc      = done && mem_zbc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= WR_OFF;
         char_q <= '0;
         line_q <= '0;
      end else if (abort) begin
         ph_q <= WR_OFF;
      end else begin
         unique case (ph_q)
            WR_OFF: if (launch) begin
               ph_q   <= WR_CHAR;
               char_q <= char_in;
               line_q <= line_in;
            end
            WR_CHAR: if (mem_ack) ph_q <= mem_err ? WR_OFF : WR_LINE;
            WR_LINE: if (mem_ack) ph_q <= WR_OFF;
            default: ph_q <= WR_OFF;
         endcase
      end
   end
endmodule

// File: rtl/chan_rx_seq.sv
module chan_rx_seq
   import chan_rx_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              halt_i,
   output logic              cmd_req_o,
   input  logic              cmd_ack_i,
   input  logic              cmd_err_i,
   output logic              end_req_o,
   input  logic              end_ack_i,
   input  logic              end_chain_i,
   input  logic              end_err_i,
   output logic              uend_o,
   output logic [3:0]        status_o,
   output logic [1:0]        state_o,
   input  logic              char_valid_i,
   output logic              char_ready_o,
   input  logic [DATA_W-1:0] char_data_i,
   input  logic [LINE_W-1:0] char_line_i,
   input  logic              char_brk_i,
   input  logic              disc_i,
   input  logic [LINE_W-1:0] disc_line_i,
   output logic              mem_req_o,
   output logic [DATA_W-1:0] mem_data_o,
   input  logic              mem_ack_i,
   input  logic              mem_err_i,
   input  logic              mem_zbc_i,
   output logic              rx_irq_o,
   output logic              xmt_irq_clr_o,
   input  logic [LINE_W-1:0] qry_line_i,
   output logic [DATA_W-1:0] qry_data_o,
   output logic              qry_brk_o
);
   if (LINES < 2) begin : g_bad_lines
      $error("chan_rx_seq: LINES must be at least 2");
   end
   if (LINE_W > DATA_W) begin : g_bad_width
      $error("chan_rx_seq: line number does not fit in one memory byte");
   end

   seq_state_t st_q, st_d;
   logic       uend_q, uend_d, irq_q, xclr_q;
   logic       wr_idle, wr_done, wr_zbc, wr_err, accept, launch;

   assign accept = char_valid_i && wr_idle;
   assign launch = accept && !char_brk_i && (st_q == SQ_RECV) && !halt_i;

   chan_rx_lines #(.LINES(LINES), .DATA_W(DATA_W)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (accept),
      .upd_line (char_line_i),
      .upd_brk  (char_brk_i),
      .upd_data (char_data_i),
      .clr_en   (disc_i),
      .clr_line (disc_line_i),
      .rd_line  (qry_line_i),
      .rd_data  (qry_data_o),
      .rd_brk   (qry_brk_o)
   );

   chan_rx_wr #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .abort    (halt_i),
      .char_in  (char_data_i),
      .line_in  (char_line_i),
      .mem_ack  (mem_ack_i),
      .mem_err  (mem_err_i),
      .mem_zbc  (mem_zbc_i),
      .mem_req  (mem_req_o),
      .mem_data (mem_data_o),
      .idle     (wr_idle),
      .done     (wr_done),
      .zbc      (wr_zbc),
      .err      (wr_err)
   );

   always_comb begin
      st_d   = st_q;
      uend_d = 1'b0;
      if (halt_i) begin
         st_d = SQ_IDLE;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (start_i) st_d = SQ_INIT;
            SQ_INIT: if (cmd_ack_i) begin
               st_d   = cmd_err_i ? SQ_IDLE : SQ_RECV;
               uend_d = cmd_err_i;
            end
            SQ_RECV: if (wr_err) begin
               st_d   = SQ_IDLE;
               uend_d = 1'b1;
            end else if (wr_zbc) begin
               st_d = SQ_END;
            end
            SQ_END: if (end_ack_i) begin
               if (end_err_i) begin
                  st_d   = SQ_IDLE;
                  uend_d = 1'b1;
               end else begin
                  st_d = end_chain_i ? SQ_INIT : SQ_IDLE;
               end
            end
            default: st_d = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         uend_q <= 1'b0;
         irq_q  <= 1'b0;
         xclr_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         uend_q <= uend_d;
         xclr_q <= halt_i;
         if (halt_i)       irq_q <= 1'b0;
         else if (wr_done) irq_q <= 1'b1;
      end
   end

   always_comb begin
      status_o             = '0;
      status_o[STAT_AUTO]  = 1'b1;
      status_o[STAT_CBUSY] = (st_q != SQ_IDLE);
      status_o[STAT_DBUSY] = (st_q != SQ_IDLE);
      status_o[STAT_CC2]   = (st_q != SQ_IDLE);
   end

   assign state_o       = st_q;
   assign cmd_req_o     = (st_q == SQ_INIT);
   assign end_req_o     = (st_q == SQ_END);
   assign uend_o        = uend_q;
   assign rx_irq_o      = irq_q;
   assign xmt_irq_clr_o = xclr_q;
   assign char_ready_o  = wr_idle;
endmodule

// File: rtl/chan_rx_seq_chk.sv
module chan_rx_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              halt_i,
   input logic [1:0]        state_o,
   input logic [3:0]        status_o,
   input logic              mem_req_o,
   input logic              mem_ack_i,
   input logic [DATA_W-1:0] mem_data_o,
   input logic              rx_irq_o,
   input logic              char_ready_o,
   input logic              end_req_o
);
   p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && start_i && !halt_i) |=> (state_o == 2'd1));

   p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i && !halt_i) |=> (mem_req_o && $stable(mem_data_o)));

   p_irq_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq_o) |-> $past(mem_req_o && mem_ack_i));

   p_end_req_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      end_req_o |-> (state_o == 2'd3));

   p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (state_o == 2'd0 && !rx_irq_o && !mem_req_o));

   p_no_write_outside_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd2) |-> !mem_req_o);

   p_busy_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd0) |-> (status_o == 4'hF));

   p_not_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !char_ready_o);
endmodule

bind chan_rx_seq chan_rx_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .halt_i       (halt_i),
   .state_o      (state_o),
   .status_o     (status_o),
   .mem_req_o    (mem_req_o),
   .mem_ack_i    (mem_ack_i),
   .mem_data_o   (mem_data_o),
   .rx_irq_o     (rx_irq_o),
   .char_ready_o (char_ready_o),
   .end_req_o    (end_req_o)
);

// File: tb/chan_rx_seq_tb.sv
module chan_rx_seq_tb;
   localparam int LINES = 8;
   localparam int DW    = 8;
   localparam int LW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, halt_i = 0, cmd_ack_i = 0, cmd_err_i = 0;
   logic end_ack_i = 0, end_chain_i = 0, end_err_i = 0;
   logic char_valid_i = 0, char_brk_i = 0, disc_i = 0;
   logic [DW-1:0] char_data_i = '0;
   logic [LW-1:0] char_line_i = '0, disc_line_i = '0, qry_line_i = '0;
   logic mem_ack_i = 0, mem_err_i = 0, mem_zbc_i = 0;
   logic cmd_req_o, end_req_o, uend_o, char_ready_o, mem_req_o, rx_irq_o, xmt_irq_clr_o, qry_brk_o;
   logic [3:0] status_o;
   logic [1:0] state_o;
   logic [DW-1:0] mem_data_o, qry_data_o;

   always #2 clk = ~clk;

   chan_rx_seq #(.LINES(LINES), .DATA_W(DW)) u_dut (.*);

   int checks = 0, errors = 0, cycles = 0;
   bit done_flag = 0;

   // reference model state
   int m_st = 0, m_wph = 0, m_char = 0, m_line = 0;
   bit m_irq = 0, m_uend = 0, m_xclr = 0;
   int m_buf [LINES];
   bit m_brk [LINES];
   string t_st = "R1", t_uend = "R1";
   bit in_reset = 1;

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      bit acc;
      string ts;
      cycles++;
      if (!rst_n) begin
         m_st = 0; m_wph = 0; m_irq = 0; m_uend = 0; m_xclr = 0;
         for (int i = 0; i < LINES; i++) begin m_buf[i] = 0; m_brk[i] = 0; end
         in_reset = 1; t_st = "R1"; t_uend = "R1";
      end else begin
         in_reset = 0;
         ts = (m_st == 0) ? "R2" : (m_st == 1) ? "R3" : (m_st == 2) ? "R5" : "R6";
         t_uend = (m_st == 2) ? "R12" : ts;
         m_uend = 0;
         m_xclr = halt_i;
         acc = char_valid_i && (m_wph == 0);
         if (acc) begin
            if (char_brk_i) m_brk[char_line_i] = 1;
            else begin m_brk[char_line_i] = 0; m_buf[char_line_i] = char_data_i; end
         end
         if (disc_i) begin m_brk[disc_line_i] = 0; m_buf[disc_line_i] = 0; end
         if (halt_i) begin
            m_st = 0; m_wph = 0; m_irq = 0; ts = "R7";
         end else begin
            case (m_st)
               0: if (start_i) m_st = 1;
               1: if (cmd_ack_i) begin
                     m_st = cmd_err_i ? 0 : 2;
                     m_uend = cmd_err_i;
                  end
               2: if (m_wph == 0) begin
                     if (acc && !char_brk_i) begin
                        m_wph = 1; m_char = char_data_i; m_line = char_line_i;
                     end
                  end else if (mem_ack_i) begin
                     if (mem_err_i) begin m_st = 0; m_wph = 0; m_uend = 1; end
                     else if (m_wph == 1) m_wph = 2;
                     else begin
                        m_wph = 0; m_irq = 1;
                        if (mem_zbc_i) m_st = 3;
                     end
                  end
               default: if (end_ack_i) begin
                     if (end_err_i) begin m_st = 0; m_uend = 1; end
                     else m_st = end_chain_i ? 1 : 0;
                  end
            endcase
         end
         t_st = ts;
      end
      #1;
      if (!done_flag) compare();
   end

   task automatic compare();
      string tm;
      int exp_data;
      tm = in_reset ? "R1" : (m_st == 2) ? "R4" : "R10";
      exp_data = (m_wph == 2) ? m_line : m_char;
      check(t_st, "state", state_o, m_st);
      check(in_reset ? "R1" : "R3", "cmd_req", cmd_req_o, m_st == 1);
      check(in_reset ? "R1" : "R6", "end_req", end_req_o, m_st == 3);
      check(tm, "mem_req", mem_req_o, m_wph != 0);
      if (m_wph != 0) check("R4", "mem_data", mem_data_o, exp_data);
      check(in_reset ? "R1" : "R5", "rx_irq", rx_irq_o, m_irq);
      check(t_uend, "uend", uend_o, m_uend);
      check(in_reset ? "R1" : "R7", "xmt_irq_clr", xmt_irq_clr_o, m_xclr);
      check(in_reset ? "R1" : "R11", "status", status_o, (m_st == 0) ? 4'b0001 : 4'b1111);
      check(in_reset ? "R1" : "R13", "char_ready", char_ready_o, m_wph == 0);
      check(in_reset ? "R1" : "R8", "qry_brk", qry_brk_o, m_brk[qry_line_i]);
      check(in_reset ? "R1" : "R9", "qry_data", qry_data_o, m_buf[qry_line_i]);
   endtask

   task automatic cyc();
      @(negedge clk);
      start_i = 0; halt_i = 0; cmd_ack_i = 0; cmd_err_i = 0;
      end_ack_i = 0; end_chain_i = 0; end_err_i = 0;
      char_valid_i = 0; char_brk_i = 0; disc_i = 0;
      mem_ack_i = 0; mem_err_i = 0; mem_zbc_i = 0;
      qry_line_i = qry_line_i + 1'b1;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic put_char(int ln, int d, bit brk);
      cyc();
      char_valid_i = 1; char_line_i = LW'(ln); char_data_i = DW'(d); char_brk_i = brk;
      cyc();
   endtask

   task automatic mem_resp(bit err, bit zbc);
      idle(2);
      mem_ack_i = 1; mem_err_i = err; mem_zbc_i = zbc;
      cyc();
   endtask

   task automatic go_recv();
      cyc(); start_i = 1;
      idle(2);
      cmd_ack_i = 1;
      cyc();
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      idle(2);
      // R10 / R8: traffic while idle only touches line state
      put_char(3, 8'h41, 0);
      put_char(3, 8'h00, 1);
      idle(8);
      // R2: start, then a second start while in init is ignored
      cyc(); start_i = 1;
      cyc(); start_i = 1;
      cyc(); cmd_ack_i = 1;
      cyc();
      // R4 / R5: one transfer without byte count exhaustion
      put_char(5, 8'h5A, 0);
      // R13: offered while busy, must not be taken
      char_valid_i = 1; char_line_i = 3'd6; char_data_i = 8'h77;
      cyc();
      mem_resp(0, 0);
      mem_resp(0, 0);
      idle(8);
      // R8: break during receive writes nothing
      put_char(2, 8'hFF, 1);
      idle(8);
      // R5 / R6: byte count zero, chained command, then plain end
      put_char(7, 8'hC3, 0);
      mem_resp(0, 0);
      mem_resp(0, 1);
      idle(1); end_ack_i = 1; end_chain_i = 1;
      cyc(); idle(1); cmd_ack_i = 1;
      cyc();
      put_char(1, 8'h1E, 0);
      mem_resp(0, 0);
      mem_resp(0, 1);
      idle(1); end_ack_i = 1;
      cyc(); idle(8);
      // R3: fetch error
      cyc(); start_i = 1;
      idle(2); cmd_ack_i = 1; cmd_err_i = 1;
      cyc(); idle(3);
      // R12: memory error on the character write
      go_recv();
      put_char(4, 8'h99, 0);
      mem_resp(1, 0);
      idle(3);
      // R7: halt in the middle of a write
      go_recv();
      put_char(6, 8'h3C, 0);
      mem_resp(0, 0);
      cyc(); halt_i = 1;
      cyc(); idle(8);
      // R6: end with error
      go_recv();
      put_char(0, 8'hA5, 0);
      mem_resp(0, 0);
      mem_resp(0, 1);
      idle(1); end_ack_i = 1; end_err_i = 1;
      cyc(); idle(3);
      // R7: halt beats start in the same cycle
      cyc(); halt_i = 1; start_i = 1;
      cyc(); idle(2);
      // R9: disconnect wins over a character on the same line
      cyc(); disc_i = 1; disc_line_i = 3'd3;
      char_valid_i = 1; char_line_i = 3'd3; char_data_i = 8'h66;
      cyc(); disc_i = 1; disc_line_i = 3'd5;
      cyc(); idle(10);
      done_flag = 1;
      summary();
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done_flag = 1;
      summary();
   end
endmodule